// File: doc/BRIEF.md
# Byte ALU with Per-Operation Flag Generation

This is a purely combinational arithmetic/logic unit for a byte-wide datapath. The caller gives it a 4-bit operation code, two byte operands, the current carry and zero flags, and, for the word modes, a 16-bit register-pair value and a 6-bit unsigned immediate. It returns the byte result, the 16-bit pair result, six flag values and a six-bit update mask. The mask tells the surrounding status register which flags this operation defines. Flags whose mask bit is clear must be kept at their previous values.

The unit covers add and subtract, each with and without incoming carry, and compare with and without carry. It also covers AND, OR and XOR, one's and two's complement, increment, decrement, load-all-ones, and add or subtract of a small immediate on a register pair. Both multi-byte arithmetic and multi-byte compares chain through the carry and zero inputs. Operand fetch, register storage and the write of the status register belong to the caller.

Top module: `alu8_core`

## Requirements
- R1: Operation codes are ADD=0 and ADC=1. The result is a+b (+carry_i for ADC) modulo 256. C is the carry out of bit 7. Z is set when the result is zero. N is result bit 7. V is signed overflow. All six flags are marked for update.
- R2: Operation codes are SUB=2, SBC=3, CMP=4 and CPC=5. The result is a-b (-carry_i for SBC/CPC) modulo 256; compare still drives that difference on result_o. C is the borrow out of bit 7. V is signed overflow. All six flags are marked for update.
- R3: For SBC and CPC, Z is set only when the result is zero and zero_i is 1. A nonzero result always clears Z.
- R4: AND=6, OR=7 and XOR=8 give the bitwise result with V=0. Only S, V, N and Z are marked (mask 6'b011110). C and H are left untouched.
- R5: COM=9 gives 0xFF-a with C=1 and V=0. The mask is 6'b011111.
- R6: NEG=10 gives 0x00-a with borrow-based flags, as in a subtract from zero. All six flags are marked.
- R7: INC=11 and DEC=12 give a+1 and a-1 modulo 256. INC sets V only for a=0x7F, and DEC sets V only for a=0x80. The mask is 6'b011110.
- R8: SER=13 gives 0xFF, and the mask is all zeros.
- R9: WADD=14 and WSUB=15 give pair±imm modulo 65536 on pair_res_o. C is the 16-bit carry or borrow. V is 16-bit signed overflow. N is bit 15. Z is set when all 16 bits are zero. The mask is 6'b011111.
- R10: Whenever S is marked, S equals N XOR V.
- R11: H is the carry out of bit 3 on add, and the borrow into bit 3 on subtract, including the carry or borrow input.
- R12: Flag and mask bit positions are C=0, Z=1, N=2, V=3, S=4, H=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First (destination) byte operand |
| b_i | input | 8 | Second byte operand |
| carry_i | input | 1 | Current C flag |
| zero_i | input | 1 | Current Z flag |
| pair_i | input | 16 | Register-pair value for word modes |
| imm_i | input | 6 | Unsigned immediate for word modes |
| result_o | output | 8 | Byte result |
| pair_res_o | output | 16 | Word-mode result |
| flags_o | output | 6 | Flag values {H,S,V,N,Z,C} |
| upd_o | output | 6 | Per-flag update mask, same bit order |

## Verification
Some rules are checked by assertions on every input combination the unit sees:
- the load-all-ones case leaves no flag marked;
- the logical operations never mark C or H and never raise V;
- SBC and CPC never set Z while zero_i is low;
- Z agrees with the byte result in the non-chained modes;
- increment overflow happens only from 0x7F;
- a word-add carry means the pair wrapped.

Only the bench's sweeps show that the exact arithmetic values are right. These cover signed overflow at both ends, the nibble carries and borrows, and the word results for every immediate. Each is compared against a separate integer model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADC  = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
    OP_CMP  = 4'd4,  OP_CPC  = 4'd5,  OP_AND = 4'd6,  OP_OR  = 4'd7,
    OP_XOR  = 4'd8,  OP_COM  = 4'd9,  OP_NEG = 4'd10, OP_INC = 4'd11,
    OP_DEC  = 4'd12, OP_SER  = 4'd13, OP_WADD = 4'd14, OP_WSUB = 4'd15
  } alu_op_e;

  // packed MSB first: h=bit5 ... c=bit0
  typedef struct packed {
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } alu_flags_t;

  localparam int unsigned NIB_W = 4;
  localparam alu_flags_t MASK_ALL   = alu_flags_t'(6'b111111);
  localparam alu_flags_t MASK_SVNZ  = alu_flags_t'(6'b011110);
  localparam alu_flags_t MASK_SVNZC = alu_flags_t'(6'b011111);
  localparam alu_flags_t MASK_NONE  = alu_flags_t'(6'b000000);
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         h_o,
  output logic         v_o
);
  import alu8_pkg::*;

  logic [W:0]     full;
  logic [NIB_W:0] nib;

  always_comb begin
    if (sub_i) begin
      full = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
      nib  = {1'b0, a_i[NIB_W-1:0]} - {1'b0, b_i[NIB_W-1:0]} - {{NIB_W{1'b0}}, cin_i};
    end else begin
      full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
      nib  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin_i};
    end
  end

  assign sum_o = full[W-1:0];
  assign c_o   = full[W];
  assign h_o   = nib[NIB_W];
  // overflow: operand signs vs result sign
  assign v_o   = sub_i ? ((a_i[W-1] != b_i[W-1]) && (full[W-1] != a_i[W-1]))
                       : ((a_i[W-1] == b_i[W-1]) && (full[W-1] != a_i[W-1]));
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int unsigned W = 8
) (
  input  alu8_pkg::alu_op_e op_i,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  output logic [W-1:0]      res_o,
  output logic              v_o
);
  import alu8_pkg::*;

  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    res_o = '0;
    v_o   = 1'b0;
    case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_COM: res_o = ~a_i;
      OP_INC: begin
        res_o = a_i + ONE;
        v_o   = (a_i == MAX_POS);
      end
      OP_DEC: begin
        res_o = a_i - ONE;
        v_o   = (a_i == MIN_NEG);
      end
      OP_SER: res_o = '1;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu8_word.sv
module alu8_word #(
  parameter int unsigned W     = 8,
  parameter int unsigned IMM_W = 6
) (
  input  logic [2*W-1:0]   pair_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             sub_i,
  output logic [2*W-1:0]   res_o,
  output logic             c_o,
  output logic             v_o,
  output logic             n_o,
  output logic             z_o
);
  localparam int unsigned PW = 2 * W;

  logic [PW:0] full;
  logic [PW:0] imm_x;

  assign imm_x = {{(PW + 1 - IMM_W){1'b0}}, imm_i};

  always_comb begin
    if (sub_i) full = {1'b0, pair_i} - imm_x;
    else       full = {1'b0, pair_i} + imm_x;
  end

  assign res_o = full[PW-1:0];
  assign c_o   = full[PW];
  // immediate is non-negative: overflow only by crossing the sign boundary
  assign v_o   = sub_i ? (pair_i[PW-1] && !full[PW-1]) : (!pair_i[PW-1] && full[PW-1]);
  assign n_o   = full[PW-1];
  assign z_o   = (full[PW-1:0] == '0);
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int unsigned W     = 8,
  parameter int unsigned IMM_W = 6
) (
  input  logic [3:0]       op_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic             carry_i,
  input  logic             zero_i,
  input  logic [2*W-1:0]   pair_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [W-1:0]     result_o,
  output logic [2*W-1:0]   pair_res_o,
  output logic [5:0]       flags_o,
  output logic [5:0]       upd_o
);
  import alu8_pkg::*;

  localparam logic [W-1:0] ALL_ONES = '1;
  localparam logic [W-1:0] INC_EDGE = {1'b0, {(W-1){1'b1}}};

  alu_op_e    op;
  logic [W-1:0] as_a, as_b, as_sum;
  logic         as_cin, as_sub, as_c, as_h, as_v;
  logic         sticky_z;
  logic [W-1:0] lg_res;
  logic         lg_v;
  logic [2*W-1:0] wd_res;
  logic         wd_c, wd_v, wd_n, wd_z;
  logic [W-1:0] res;
  alu_flags_t   fl, mask;

  assign op = alu_op_e'(op_i);

  // operand steering for the shared byte adder
  always_comb begin
    as_a     = a_i;
    as_b     = b_i;
    as_cin   = 1'b0;
    as_sub   = 1'b0;
    sticky_z = 1'b0;
    case (op)
      OP_ADC: as_cin = carry_i;
      OP_SUB, OP_CMP: as_sub = 1'b1;
      OP_SBC, OP_CPC: begin
        as_sub   = 1'b1;
        as_cin   = carry_i;
        sticky_z = 1'b1;
      end
      OP_NEG: begin
        as_a   = '0;
        as_b   = a_i;
        as_sub = 1'b1;
      end
      default: ;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .a_i   (as_a),
    .b_i   (as_b),
    .cin_i (as_cin),
    .sub_i (as_sub),
    .sum_o (as_sum),
    .c_o   (as_c),
    .h_o   (as_h),
    .v_o   (as_v)
  );

  alu8_logic #(.W(W)) u_logic (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (lg_res),
    .v_o   (lg_v)
  );

  alu8_word #(.W(W), .IMM_W(IMM_W)) u_word (
    .pair_i (pair_i),
    .imm_i  (imm_i),
    .sub_i  (op == OP_WSUB),
    .res_o  (wd_res),
    .c_o    (wd_c),
    .v_o    (wd_v),
    .n_o    (wd_n),
    .z_o    (wd_z)
  );

  always_comb begin
    res  = '0;
    fl   = '0;
    mask = MASK_NONE;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CPC, OP_NEG: begin
        res  = as_sum;
        fl.c = as_c;
        fl.h = as_h;
        fl.v = as_v;
        fl.n = as_sum[W-1];
        fl.z = (as_sum == '0) && (!sticky_z || zero_i);
        mask = MASK_ALL;
      end
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
        res  = lg_res;
        fl.v = lg_v;
        fl.n = lg_res[W-1];
        fl.z = (lg_res == '0);
        mask = MASK_SVNZ;
      end
      OP_COM: begin
        res  = lg_res;
        fl.c = 1'b1;
        fl.n = lg_res[W-1];
        fl.z = (lg_res == '0);
        mask = MASK_SVNZC;
      end
      OP_SER: res = lg_res;
      OP_WADD, OP_WSUB: begin
        res  = wd_res[W-1:0];
        fl.c = wd_c;
        fl.v = wd_v;
        fl.n = wd_n;
        fl.z = wd_z;
        mask = MASK_SVNZC;
      end
      default: ;
    endcase
    fl.s = fl.n ^ fl.v;
  end

  assign result_o   = res;
  assign pair_res_o = wd_res;
  assign flags_o    = fl;
  assign upd_o      = mask;

  always_comb begin
    if (op == OP_SER)
      AST_SER_NO_FLAGS: assert (upd_o == 6'b0 && result_o == ALL_ONES) else $error("set op"); // R8
    if (op == OP_AND || op == OP_OR || op == OP_XOR)
      AST_LOGIC_KEEP_CH: assert (!flags_o[3] && !upd_o[0] && !upd_o[5]) else $error("logic flags"); // R4
    if (op == OP_INC && flags_o[3])
      AST_INC_OVF_EDGE: assert (a_i == INC_EDGE) else $error("inc overflow"); // R7
    if ((op == OP_SBC || op == OP_CPC) && !zero_i)
      AST_STICKY_ZERO: assert (!flags_o[1]) else $error("sticky zero"); // R3
    if (upd_o[1] && op != OP_SBC && op != OP_CPC && op != OP_WADD && op != OP_WSUB)
      AST_ZERO_MATCH: assert (flags_o[1] == (result_o == '0)) else $error("zero flag"); // R1
    if (op == OP_WADD && flags_o[0])
      AST_WORD_CARRY: assert (pair_res_o < pair_i) else $error("word carry"); // R9
  end
endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic [3:0] op;
  logic [7:0] a, b;
  logic       cin, zin;
  logic [15:0] pair;
  logic [5:0]  imm;
  logic [7:0]  result;
  logic [15:0] pair_res;
  logic [5:0]  flags, upd;

  int checks = 0;
  int failures = 0;

  always #(CLK_P / 2) clk = ~clk;

  alu8_core dut (
    .op_i       (op),
    .a_i        (a),
    .b_i        (b),
    .carry_i    (cin),
    .zero_i     (zin),
    .pair_i     (pair),
    .imm_i      (imm),
    .result_o   (result),
    .pair_res_o (pair_res),
    .flags_o    (flags),
    .upd_o      (upd)
  );

  function automatic int sx8(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int sx16(int v);
    return (v > 32767) ? v - 65536 : v;
  endfunction

  task automatic check_byte(int o, int av, int bv, int c_in, int z_in, string tag);
    int r, ci, aa, bb, sr, c, h, v, n, z, s, m, ef;
    string t;
    op = 4'(o); a = 8'(av); b = 8'(bv); cin = 1'(c_in); zin = 1'(z_in);
    pair = 16'h1234; imm = 6'd5;
    #(CLK_P);
    ci = (o == 1 || o == 3 || o == 5) ? c_in : 0;
    c = 0; h = 0; v = 0; m = 0; t = "R1";
    case (o)
      0, 1: begin
        r = av + bv + ci;
        c = (r > 255) ? 1 : 0;
        h = (((av % 16) + (bv % 16) + ci) > 15) ? 1 : 0;
        sr = sx8(av) + sx8(bv) + ci;
        v = (sr > 127 || sr < -128) ? 1 : 0;
        r = r % 256; m = 63; t = "R1";
      end
      2, 3, 4, 5, 10: begin
        aa = (o == 10) ? 0 : av;
        bb = (o == 10) ? av : bv;
        r = aa - bb - ci;
        c = (r < 0) ? 1 : 0;
        h = (((aa % 16) - (bb % 16) - ci) < 0) ? 1 : 0;
        sr = sx8(aa) - sx8(bb) - ci;
        v = (sr > 127 || sr < -128) ? 1 : 0;
        r = (r + 512) % 256; m = 63;
        t = (o == 10) ? "R6" : ((o == 3 || o == 5) ? "R3" : "R2");
      end
      6: begin r = av & bv; m = 30; t = "R4"; end
      7: begin r = av | bv; m = 30; t = "R4"; end
      8: begin r = av ^ bv; m = 30; t = "R4"; end
      9: begin r = 255 - av; c = 1; m = 31; t = "R5"; end
      11: begin r = (av + 1) % 256; v = (sx8(av) + 1 > 127) ? 1 : 0; m = 30; t = "R7"; end
      12: begin r = (av + 255) % 256; v = (sx8(av) - 1 < -128) ? 1 : 0; m = 30; t = "R7"; end
      default: begin r = 255; m = 0; t = "R8"; end
    endcase
    n = (r >> 7) & 1;
    z = (r == 0) ? 1 : 0;
    if (o == 3 || o == 5) z = z & z_in;
    s = n ^ v;
    ef = (h << 5) | (s << 4) | (v << 3) | (n << 2) | (z << 1) | c;
    if (tag != "") t = tag;
    checks++;
    if (int'(result) != r || int'(upd) != m || (int'(flags) & m) != (ef & m)) begin
      failures++;
      $display("FAIL %s op=%0d a=%02h b=%02h cin=%0d zin=%0d: res=%02h flags=%06b upd=%06b exp res=%02h flags=%06b upd=%06b",
               t, o, av, bv, c_in, z_in, result, flags & 6'(m), upd, r, ef & m, m);
    end
  endtask

  task automatic check_word(int o, int w, int iv);
    int r, c, v, n, z, s, sr, ef;
    op = 4'(o); pair = 16'(w); imm = 6'(iv); a = 8'h5A; b = 8'hA5; cin = 1'b1; zin = 1'b1;
    #(CLK_P);
    if (o == 14) begin
      r = w + iv; c = (r > 65535) ? 1 : 0; sr = sx16(w) + iv;
    end else begin
      r = w - iv; c = (r < 0) ? 1 : 0; sr = sx16(w) - iv;
    end
    v = (sr > 32767 || sr < -32768) ? 1 : 0;
    r = (r + 131072) % 65536;
    n = (r >> 15) & 1;
    z = (r == 0) ? 1 : 0;
    s = n ^ v;
    ef = (s << 4) | (v << 3) | (n << 2) | (z << 1) | c;
    checks++;
    if (int'(pair_res) != r || int'(upd) != 31 || (int'(flags) & 31) != ef) begin
      failures++;
      $display("FAIL R9 op=%0d pair=%04h imm=%0d: res=%04h flags=%06b upd=%06b exp res=%04h flags=%06b upd=011111",
               o, w, iv, pair_res, flags & 6'h1F, upd, r, ef);
    end
  endtask

  initial begin
    int blist[12] = '{0, 1, 15, 16, 60, 127, 128, 129, 165, 240, 254, 255};
    int wlist[12] = '{0, 1, 63, 64, 255, 4095, 32704, 32767, 32768, 32800, 65472, 65535};
    // quiescent state: add of zeros
    check_byte(0, 0, 0, 0, 0, "R1");
    // directed corners
    check_byte(0, 8'h0F, 8'h01, 0, 0, "R11");   // nibble carry
    check_byte(2, 8'h10, 8'h01, 0, 0, "R11");   // nibble borrow
    check_byte(1, 8'h0E, 8'h01, 1, 0, "R11");   // carry in reaches nibble
    check_byte(0, 8'h80, 8'h80, 0, 0, "R10");   // V=1,N=0 -> S=1
    check_byte(2, 8'h80, 8'h01, 0, 0, "R10");
    check_byte(6, 8'hF0, 8'h0F, 0, 0, "R12");   // mask positions
    check_byte(9, 8'h00, 8'h00, 0, 0, "R12");
    check_byte(5, 8'h12, 8'h12, 0, 0, "R3");    // equal but prior Z clear
    check_byte(5, 8'h12, 8'h12, 0, 1, "R3");
    check_byte(10, 8'h80, 8'h00, 0, 0, "R6");
    check_byte(11, 8'h7F, 8'h00, 0, 0, "R7");
    check_byte(12, 8'h80, 8'h00, 0, 0, "R7");
    check_byte(13, 8'h00, 8'h00, 1, 1, "R8");
    // sweep: every op, every first operand, corner second operands
    for (int o = 0; o < 14; o++)
      for (int av = 0; av < 256; av++)
        for (int bi = 0; bi < 12; bi++)
          check_byte(o, av, blist[bi], (av ^ blist[bi]) & 1, ((av >> 1) ^ bi) & 1, "");
    // word modes: every immediate over corner pair values
    for (int o = 14; o < 16; o++)
      for (int wi = 0; wi < 12; wi++)
        for (int iv = 0; iv < 64; iv++)
          check_word(o, wlist[wi], iv);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule